// File: doc/BRIEF.md
# Unaligned Word Store Write Generator

This block turns one 32-bit store, placed at any byte offset inside an 8-byte window, into the write bursts needed on a 64-bit write bus. The store arrives as a byte address and a data word under a valid/ready handshake. The block then drives the write address channel and the write data channel, and collects the write responses. Only address bits [2:0] choose the burst shape. The upper bits are carried through unchanged, except for the second burst of a split store, which goes to the next 8-byte window.

The low offset picks the transfer size, the beat count, the strobe pattern and whether one or two bursts are used. These shapes include 64-bit single beats for offsets 1 and 2, a trailing beat with an all-zero strobe for offset 3, and two separate 16-bit bursts for offset 6. The store bytes are shifted onto the byte lanes that their strobes enable. The block takes no new store until every response for the current one has arrived. It then gives a one-cycle completion pulse that carries an error flag.

The controller runs through seven named states:
- `S_IDLE` is left for `S_AW1` when a store is accepted.
- `S_AW1` goes to `S_W1` when the first address is accepted.
- `S_W1` goes to `S_AW2` (split store) or to `S_RESP` on the last beat of the first burst.
- `S_AW2` goes to `S_W2` when the second address is accepted.
- `S_W2` goes to `S_RESP` on its single beat.
- `S_RESP` goes to `S_DONE` once all expected responses have been counted.
- `S_DONE` returns to `S_IDLE` after one cycle.

Top module: `ustw_top`

## Requirements
- R1: After reset, `st_ready` is 1 and `awvalid`, `wvalid` and `done_valid` are 0.
- R2: Every burst uses INCR type (`awburst`=2'b01) and `awlen` = beats-1. The size codes are 3'b001 for 16-bit, 3'b010 for 32-bit and 3'b011 for 64-bit. Offset 0 issues address low bits 0, 32-bit, 1 beat, strobe 0x0F. Offset 4 issues address low bits 4, 32-bit, 1 beat, strobe 0xF0.
- R3: Offset 1 issues address low bits 1, 64-bit, 1 beat, strobe 0x1E. Offset 2 issues address low bits 0, 64-bit, 1 beat, strobe 0x3C.
- R4: Offset 3 issues address low bits 3, 64-bit, 2 beats, with strobes 0x78 and then 0x00.
- R5: Offset 5 issues address low bits 5, 32-bit, 2 beats, with strobes 0xE0 and then 0x01.
- R6: Offset 7 issues address low bits 4, 32-bit, 2 beats, with strobes 0x80 and then 0x07.
- R7: Offset 6 issues two 16-bit single-beat bursts. The first has address low bits 6 and strobe 0xC0. The second has address ((addr>>3)+1)<<3 and strobe 0x03. The second address appears only after the first address has been accepted and its data beat has been sent. In every other case, address bits above bit 2 equal the store address.
- R8: Store byte i (bits 8i+7..8i) appears on lane (offset+i) mod 8 of data beat (offset+i) div 8. Lanes with a zero strobe carry 0. Beats are counted across both bursts of a split store.
- R9: `wlast` is 1 on the final beat of each burst and 0 on the other beats.
- R10: While `awvalid` or `wvalid` waits for its ready, it stays 1 and its payload stays unchanged.
- R11: `st_ready` is 0 from the acceptance of a store until its completion. `done_valid` is a single-cycle pulse that follows the last expected response, and `st_ready` is 1 in the next cycle.
- R12: `done_err` is 1 with `done_valid` if and only if any response for that store had `bresp` other than 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Block can accept a store |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 32 | Store data word, byte 0 in bits 7:0 |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Burst start address |
| awburst | output | 2 | Burst type (always INCR) |
| awsize | output | 3 | Transfer size code |
| awlen | output | 8 | Beats minus one |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | 64 | Write data lanes |
| wstrb | output | 8 | Byte lane strobes |
| wlast | output | 1 | Final beat of the burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| done_valid | output | 1 | Store completion pulse |
| done_err | output | 1 | A response for the store was not OKAY |

## Verification
The assertions watch the following on every cycle:
- INCR burst type and payload stability while a valid waits (R10).
- No bus activity while the input is ready.
- The single-cycle completion pulse and the return to ready.
- The bounds of a strobe (at most four lanes).
- The shape limits of 64-bit and 16-bit bursts.

The exact address, size, length, strobe and data of each offset, the ordering of the split bursts, the beat marked last and the error reduction over two responses can only be shown by the bench's scenarios. The bench runs all eight offsets under several ready and response stall patterns.

// File: rtl/ustw_pkg.sv
package ustw_pkg;

    localparam int BUS_BYTES  = 8;
    localparam int WORD_BYTES = 4;
    localparam int BUS_W      = BUS_BYTES * 8;
    localparam int WORD_W     = WORD_BYTES * 8;
    localparam int OFS_W      = $clog2(BUS_BYTES);

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [2:0] SZ_16      = 3'b001;
    localparam logic [2:0] SZ_32      = 3'b010;
    localparam logic [2:0] SZ_64      = 3'b011;
    localparam logic [1:0] RESP_OKAY  = 2'b00;

    typedef enum logic [2:0] {
        S_IDLE,
        S_AW1,
        S_W1,
        S_AW2,
        S_W2,
        S_RESP,
        S_DONE
    } wr_state_e;

    // Shape of the first (or only) burst of a store.
    typedef struct packed {
        logic [OFS_W-1:0] lo;        // low address bits issued
        logic [2:0]       size;      // transfer size code
        logic             two_beats; // burst carries two beats
        logic             split;     // a second 16-bit burst follows
    } store_plan_t;

    function automatic store_plan_t plan_for_offset(input logic [OFS_W-1:0] ofs);
        store_plan_t p;
        p = '{lo: ofs, size: SZ_32, two_beats: 1'b0, split: 1'b0};
        unique case (ofs)
            3'd0: p = '{lo: 3'd0, size: SZ_32, two_beats: 1'b0, split: 1'b0};
            3'd1: p = '{lo: 3'd1, size: SZ_64, two_beats: 1'b0, split: 1'b0};
            3'd2: p = '{lo: 3'd0, size: SZ_64, two_beats: 1'b0, split: 1'b0};
            3'd3: p = '{lo: 3'd3, size: SZ_64, two_beats: 1'b1, split: 1'b0};
            3'd4: p = '{lo: 3'd4, size: SZ_32, two_beats: 1'b0, split: 1'b0};
            3'd5: p = '{lo: 3'd5, size: SZ_32, two_beats: 1'b1, split: 1'b0};
            3'd6: p = '{lo: 3'd6, size: SZ_16, two_beats: 1'b0, split: 1'b1};
            3'd7: p = '{lo: 3'd4, size: SZ_32, two_beats: 1'b1, split: 1'b0};
            default: p = '{lo: ofs, size: SZ_32, two_beats: 1'b0, split: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/ustw_plan.sv
module ustw_plan
    import ustw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] first_addr,
    output logic [2:0]        first_size,
    output logic              first_two,
    output logic [ADDR_W-1:0] second_addr,
    output logic              split
);
    localparam int UPPER_W = ADDR_W - OFS_W;

    store_plan_t       plan;
    logic [UPPER_W-1:0] upper;

    always_comb begin
        plan        = plan_for_offset(base_addr[OFS_W-1:0]);
        upper       = base_addr[ADDR_W-1:OFS_W];
        first_addr  = {upper, plan.lo};
        first_size  = plan.size;
        first_two   = plan.two_beats;
        split       = plan.split;
        second_addr = {upper + UPPER_W'(1), {OFS_W{1'b0}}};
    end

endmodule

// File: rtl/ustw_lanes.sv
module ustw_lanes
    import ustw_pkg::*;
(
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] word,
    input  logic              beat_sel,
    output logic [BUS_W-1:0]  data,
    output logic [BUS_BYTES-1:0] strb
);
    localparam int REL_W = OFS_W + 2;

    for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
        logic [REL_W-1:0] rel;
        logic [7:0]       lane_byte;
        logic             lane_on;

        always_comb begin
            // position of this lane within the 16-byte window, relative to the store
            rel = {1'b0, beat_sel, OFS_W'(l)} - {2'b00, ofs};
            if (rel < REL_W'(WORD_BYTES)) begin
                lane_on   = 1'b1;
                lane_byte = word[8*rel[1:0] +: 8];
            end else begin
                lane_on   = 1'b0;
                lane_byte = 8'h00;
            end
        end

        assign data[8*l +: 8] = lane_byte;
        assign strb[l]        = lane_on;
    end

endmodule

// File: rtl/ustw_resp.sv
module ustw_resp
    import ustw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       fire,
    input  logic [1:0] resp,
    output logic [1:0] count,
    output logic       err
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= 2'd0;
            err   <= 1'b0;
        end else if (fire) begin
            count <= count + 2'd1;
            if (resp != RESP_OKAY) begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ustw_top.sv
module ustw_top
    import ustw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [31:0]       st_data,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [1:0]        awburst,
    output logic [2:0]        awsize,
    output logic [7:0]        awlen,
    output logic              wvalid,
    input  logic              wready,
    output logic [63:0]       wdata,
    output logic [7:0]        wstrb,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready,
    input  logic [1:0]        bresp,
    output logic              done_valid,
    output logic              done_err
);
    wr_state_e state, state_nx;

    logic [ADDR_W-1:0] cap_addr;
    logic [WORD_W-1:0] cap_data;
    logic              beat_idx;

    logic [ADDR_W-1:0] first_addr, second_addr;
    logic [2:0]        first_size;
    logic              first_two, split;
    logic [BUS_W-1:0]  lane_data;
    logic [BUS_BYTES-1:0] lane_strb;
    logic [1:0]        rsp_cnt;
    logic              rsp_err;
    logic [1:0]        rsp_need;

    ustw_plan #(.ADDR_W(ADDR_W)) i_plan (
        .base_addr  (cap_addr),
        .first_addr (first_addr),
        .first_size (first_size),
        .first_two  (first_two),
        .second_addr(second_addr),
        .split      (split)
    );

    ustw_lanes i_lanes (
        .ofs     (cap_addr[OFS_W-1:0]),
        .word    (cap_data),
        .beat_sel(beat_idx),
        .data    (lane_data),
        .strb    (lane_strb)
    );

    ustw_resp i_resp (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == S_DONE),
        .fire (bvalid && bready),
        .resp (bresp),
        .count(rsp_cnt),
        .err  (rsp_err)
    );

    assign rsp_need = split ? 2'd2 : 2'd1;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Store capture and beat index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            beat_idx <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (st_valid) begin
                        cap_addr <= st_addr;
                        cap_data <= st_data;
                        beat_idx <= 1'b0;
                    end
                end
                S_W1: begin
                    if (wready && !wlast) begin
                        beat_idx <= 1'b1;
                    end
                end
                S_AW2: begin
                    if (awready) begin
                        beat_idx <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (st_valid) state_nx = S_AW1;
            S_AW1:  if (awready)  state_nx = S_W1;
            S_W1:   if (wready && wlast) state_nx = split ? S_AW2 : S_RESP;
            S_AW2:  if (awready)  state_nx = S_W2;
            S_W2:   if (wready)   state_nx = S_RESP;
            S_RESP: if (rsp_cnt == rsp_need) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        st_ready   = (state == S_IDLE);
        awvalid    = (state == S_AW1) || (state == S_AW2);
        awburst    = BURST_INCR;
        awaddr     = (state == S_AW2) ? second_addr : first_addr;
        awsize     = (state == S_AW2) ? SZ_16 : first_size;
        awlen      = (state == S_AW2) ? 8'd0 : {7'd0, first_two};
        wvalid     = (state == S_W1) || (state == S_W2);
        wdata      = lane_data;
        wstrb      = lane_strb;
        wlast      = (state == S_W2) || ((state == S_W1) && (beat_idx == first_two));
        bready     = (state != S_IDLE) && (state != S_DONE);
        done_valid = (state == S_DONE);
        done_err   = (state == S_DONE) && rsp_err;
    end

endmodule

// File: rtl/ustw_chk.sv
module ustw_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_ready,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic [1:0]        awburst,
    input logic [2:0]        awsize,
    input logic [7:0]        awlen,
    input logic              wvalid,
    input logic              wready,
    input logic [63:0]       wdata,
    input logic [7:0]        wstrb,
    input logic              wlast,
    input logic              done_valid
);
    // R10
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awsize) && $stable(awlen));

    // R10
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> !awvalid && !wvalid);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid && st_ready);

    // R2
    incr_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> awburst == 2'b01);

    // R8
    strb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid |-> $countones(wstrb) <= 4);

    // R3
    wide_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && awsize == 3'b011 |-> awlen <= 8'd1);

    // R7
    half_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && awsize == 3'b001 |-> awlen == 8'd0 && !awaddr[0]);

endmodule

bind ustw_top ustw_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_ready  (st_ready),
    .awvalid   (awvalid),
    .awready   (awready),
    .awaddr    (awaddr),
    .awburst   (awburst),
    .awsize    (awsize),
    .awlen     (awlen),
    .wvalid    (wvalid),
    .wready    (wready),
    .wdata     (wdata),
    .wstrb     (wstrb),
    .wlast     (wlast),
    .done_valid(done_valid)
);

// File: tb/test_ustw_top.sv
module test_ustw_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0;
    logic          st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [31:0]   st_data = '0;
    logic          awvalid, awready = 1'b0;
    logic [AW-1:0] awaddr;
    logic [1:0]    awburst;
    logic [2:0]    awsize;
    logic [7:0]    awlen;
    logic          wvalid, wready = 1'b0;
    logic [63:0]   wdata;
    logic [7:0]    wstrb;
    logic          wlast;
    logic          bvalid = 1'b0, bready;
    logic [1:0]    bresp = 2'b00;
    logic          done_valid, done_err;

    always #4 clk = ~clk;

    ustw_top #(.ADDR_W(AW)) i_ustw_top (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awburst(awburst),
        .awsize(awsize), .awlen(awlen),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .done_valid(done_valid), .done_err(done_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int stall = 0;
    int bursts_pending = 0;
    bit b_taken = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [2:0]    size;
        logic [7:0]    len;
        string         req;
    } aw_item_t;

    typedef struct {
        logic [63:0] data;
        logic [7:0]  strb;
        logic        last;
        string       req;
    } w_item_t;

    aw_item_t   aw_q[$];
    w_item_t    w_q[$];
    logic [1:0] b_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: pops expected items as handshakes occur
    always @(negedge clk) begin
        if (rst_n) begin
            if (awvalid && awready) begin
                aw_item_t e;
                if (aw_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected address", awaddr, 0);
                end else begin
                    e = aw_q.pop_front();
                    check(awaddr == e.addr, e.req, "awaddr", awaddr, e.addr);
                    check(awsize == e.size, e.req, "awsize", awsize, e.size);
                    check(awlen == e.len, e.req, "awlen", awlen, e.len);
                    check(awburst == 2'b01, "R2", "awburst", awburst, 2'b01);
                end
            end
            if (wvalid && wready) begin
                w_item_t e;
                if (w_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected beat", wdata, 0);
                end else begin
                    e = w_q.pop_front();
                    check(wstrb == e.strb, e.req, "wstrb", wstrb, e.strb);
                    check(wdata == e.data, "R8", "wdata", wdata, e.data);
                    check(wlast == e.last, "R9", "wlast", wlast, e.last);
                end
                if (wlast) bursts_pending++;
            end
            if (bvalid && bready) b_taken = 1'b1;
        end
    end

    // Slave side: ready patterns and responses, driven after the edge
    always @(posedge clk) begin
        cyc++;
        #1;
        case (stall)
            0: begin awready = 1'b1; wready = 1'b1; end
            1: begin awready = (cyc % 3 == 2); wready = (cyc % 2 == 0); end
            default: begin awready = (cyc % 5 != 0); wready = (cyc % 3 != 1); end
        endcase
        if (b_taken) begin
            bvalid  = 1'b0;
            b_taken = 1'b0;
        end else if (!bvalid && bursts_pending > 0 && (stall == 0 || cyc % 2 == 0)) begin
            bvalid = 1'b1;
            bresp  = (b_q.size() > 0) ? b_q.pop_front() : 2'b00;
            bursts_pending--;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            finish_run();
        end
    end

    task automatic push_aw(input logic [AW-1:0] a, input logic [2:0] s, input logic [7:0] l,
                           input string r);
        aw_item_t e;
        e.addr = a; e.size = s; e.len = l; e.req = r;
        aw_q.push_back(e);
    endtask

    task automatic push_w(input logic [63:0] d, input logic [7:0] s, input logic l,
                          input string r);
        w_item_t e;
        e.data = d; e.strb = s; e.last = l; e.req = r;
        w_q.push_back(e);
    endtask

    // Driver: builds the expected items from the requirements, then issues the store
    task automatic do_store(input logic [AW-1:0] addr, input logic [31:0] data,
                            input logic [1:0] r0, input logic [1:0] r1);
        logic [2:0]    o;
        logic [127:0]  wide;
        logic [63:0]   b0, b1;
        logic [AW-1:0] up;
        bit            two;
        bit            exp_err;
        bit            busy_bad;
        int            n;
        o    = addr[2:0];
        wide = {96'd0, data} << (8 * o);
        b0   = wide[63:0];
        b1   = wide[127:64];
        up   = {addr[AW-1:3], 3'b000};
        two  = 1'b0;
        case (o)
            3'd0: begin push_aw(up,      3'b010, 8'd0, "R2"); push_w(b0, 8'h0F, 1'b1, "R2"); end
            3'd1: begin push_aw(up + 1,  3'b011, 8'd0, "R3"); push_w(b0, 8'h1E, 1'b1, "R3"); end
            3'd2: begin push_aw(up,      3'b011, 8'd0, "R3"); push_w(b0, 8'h3C, 1'b1, "R3"); end
            3'd3: begin push_aw(up + 3,  3'b011, 8'd1, "R4");
                        push_w(b0, 8'h78, 1'b0, "R4"); push_w(b1, 8'h00, 1'b1, "R4"); end
            3'd4: begin push_aw(up + 4,  3'b010, 8'd0, "R2"); push_w(b0, 8'hF0, 1'b1, "R2"); end
            3'd5: begin push_aw(up + 5,  3'b010, 8'd1, "R5");
                        push_w(b0, 8'hE0, 1'b0, "R5"); push_w(b1, 8'h01, 1'b1, "R5"); end
            3'd6: begin push_aw(up + 6,  3'b001, 8'd0, "R7"); push_w(b0, 8'hC0, 1'b1, "R7");
                        push_aw(up + 8,  3'b001, 8'd0, "R7"); push_w(b1, 8'h03, 1'b1, "R7");
                        two = 1'b1; end
            default: begin push_aw(up + 4, 3'b010, 8'd1, "R6");
                        push_w(b0, 8'h80, 1'b0, "R6"); push_w(b1, 8'h07, 1'b1, "R6"); end
        endcase
        b_q.push_back(r0);
        if (two) b_q.push_back(r1);
        exp_err = (r0 != 2'b00) || (two && r1 != 2'b00);

        @(posedge clk); #1;
        st_valid = 1'b1; st_addr = addr; st_data = data;
        do @(negedge clk); while (!st_ready);
        @(posedge clk); #1;
        st_valid = 1'b0;

        busy_bad = 1'b0;
        n = 0;
        while (n < 2000) begin
            @(negedge clk);
            if (done_valid) break;
            if (st_ready) busy_bad = 1'b1;
            n++;
        end
        check(done_valid == 1'b1, "R11", "completion pulse seen", done_valid, 1);
        check(!busy_bad, "R11", "st_ready low while busy", busy_bad, 0);
        check(done_err == exp_err, "R12", "done_err", done_err, exp_err);
        check(aw_q.size() == 0 && w_q.size() == 0, "R7", "all bursts issued",
              aw_q.size() + w_q.size(), 0);
        @(negedge clk);
        check(st_ready == 1'b1 && !done_valid, "R11", "ready after completion", st_ready, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(st_ready == 1'b1, "R1", "st_ready after reset", st_ready, 1);
        check(!awvalid && !wvalid, "R1", "bus idle after reset", {awvalid, wvalid}, 0);
        check(!done_valid, "R1", "done_valid after reset", done_valid, 0);

        // All offsets, no stalls, OKAY responses
        stall = 0;
        for (int o = 0; o < 8; o++) do_store(32'h0000_1000 + o, 32'hA1B2_C3D4, 2'b00, 2'b00);

        // All offsets with ready stalls, crossing an upper-address boundary (R7)
        stall = 1;
        for (int o = 0; o < 8; o++) do_store(32'h0000_2FF8 + o, 32'h1122_3344 + o, 2'b00, 2'b00);

        // Error responses (R12) under another stall pattern
        stall = 2;
        do_store(32'h0000_3006, 32'hDEAD_BEEF, 2'b00, 2'b10);
        do_store(32'h0000_3003, 32'hCAFE_F00D, 2'b11, 2'b00);
        do_store(32'h0000_3000, 32'h0BAD_F00D, 2'b00, 2'b00);
        do_store(32'hFFFF_FFFE, 32'h5566_7788, 2'b10, 2'b00);
        for (int o = 0; o < 8; o++) do_store(32'h0040_0000 + o, 32'hF00F_0FF0 ^ o, 2'b00, 2'b00);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule